// File: doc/BRIEF.md
# Banked Effective Address Generator

This block turns one memory operand of an 8/16-bit processor with banked addressing into a 24-bit bank:address. It takes the addressing mode, the operand bytes already fetched, and the processor's address state. That state is the two index registers, the direct page base, the stack pointer, the data and program bank registers, and the narrow-index flag.

Modes that need no memory lookup produce their result one cycle after `start`. Indirect modes first read a 16-bit or 24-bit pointer through a request/acknowledge port. They combine the returned pointer with the bank and index, and present the result one cycle after the acknowledge.

All inputs are captured when `start` is accepted, so the instruction sequencer may change them while a pointer read is outstanding. The mode codes are: 0 absolute data, 1 absolute control, 2 absolute+X, 3 absolute+Y, 4 long, 5 long+X, 6 direct, 7 direct+X, 8 direct+Y, 9 stack-relative, 10 direct indirect, 11 direct indexed-indirect X, 12 direct indirect+Y, 13 direct indirect long, 14 direct indirect long+Y, 15 stack-relative indirect+Y, 16 jump indirect, 17 jump indexed-indirect X. Unlisted codes behave as code 0. The operand bus holds byte 0 in bits 7:0, byte 1 in bits 15:8 and byte 2 in bits 23:16.

Top module: `ea_gen`

## Requirements
- R1: Under synchronous active-high reset, `ea_valid`, `ptr_req`, `busy` and `ea` are all zero.
- R2: Mode 0 yields {data bank, byte1, byte0} and mode 1 yields {program bank, byte1, byte0`}. For every non-indirect mode (codes 0 to 9), `ea_valid` is high in the cycle after the `start` cycle.
- R3: Modes 2 and 3 add the index (X or Y) to the 24-bit value {data bank, byte1, byte0}, so a carry out of bit 15 increments the bank.
- R4: Mode 4 yields {byte2, byte1, byte0}. Mode 5 adds X to that 24-bit value, wrapping modulo 2^24.
- R5: Modes 6, 7 and 8 yield bank 0 with the 16-bit sum of the direct page base, byte0, and (for 7 and 8) X or Y. Mode 9 yields bank 0 with stack pointer plus byte0. All of these sums wrap within 16 bits.
- R6: When `idx_narrow` is 1, bits 15:8 of both X and Y are treated as zero in every mode that uses an index.
- R7: For indirect modes (codes 10 to 17), `ptr_req` rises in the cycle after `start`. `ptr_long` is 1 only for modes 13 and 14. The pointer address is bank 0 at direct page plus byte0 for modes 10, 12, 13 and 14, and also adds X for mode 11. It is bank 0 at stack pointer plus byte0 for mode 15.
- R8: `ptr_req` and `ptr_addr` stay unchanged until a cycle with `ptr_ack` high. In the next cycle `ea_valid` is high and `ptr_req` is low.
- R9: After the pointer returns, the result is as follows. Modes 10 and 11 give {data bank, pointer}. Modes 12 and 15 give {data bank, pointer} plus Y, with carry into the bank. Mode 13 gives the 24-bit pointer, and mode 14 gives the 24-bit pointer plus Y. For word pointers (all but 13 and 14), `ptr_data[23:16]` is ignored.
- R10: Mode 16 reads its pointer at bank 0, address {byte1, byte0}. Mode 17 reads it at {program bank, (byte1:byte0 + X) modulo 2^16}. Both give {program bank, pointer}.
- R11: While `busy` is high, `start` is ignored: no extra `ea_valid`, and the outstanding pointer read and its final result are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an address computation (accepted when not busy) |
| mode | input | 5 | Addressing-mode code |
| opnd | input | 24 | Operand bytes: byte0 [7:0], byte1 [15:8], byte2 [23:16] |
| idx_x | input | 16 | X index register |
| idx_y | input | 16 | Y index register |
| dpage | input | 16 | Direct page base register |
| sptr | input | 16 | Stack pointer |
| dbank | input | 8 | Data bank register |
| pbank | input | 8 | Program bank register |
| idx_narrow | input | 1 | 1 = index registers are 8 bits wide |
| ptr_req | output | 1 | Pointer read request |
| ptr_addr | output | 24 | Pointer read address |
| ptr_long | output | 1 | 1 = read 24-bit pointer, 0 = 16-bit |
| ptr_ack | input | 1 | Pointer data valid this cycle |
| ptr_data | input | 24 | Returned pointer |
| ea | output | 24 | Effective address |
| ea_valid | output | 1 | One-cycle strobe: `ea` is valid |
| busy | output | 1 | Pointer read outstanding |

## Verification
The assertions assume that the memory port only raises `ptr_ack` while `ptr_req` is high. They also assume `ptr_ack` is a single-cycle response to each request. The bench meets this by raising the acknowledge for exactly one cycle, and only after it has seen the request, with a chosen number of wait cycles in between. Inputs are changed only on the falling edge, so each captured context is unambiguous. The busy-time `start` pulse in the R11 scenario also changes the mode and operands, which would expose any recapture.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int LONG_W = 24;
  localparam int BANK_W = LONG_W - WORD_W;
  localparam int MODE_W = 5;

  typedef enum logic [MODE_W-1:0] {
    M_ABS_DATA   = 5'd0,
    M_ABS_CTRL   = 5'd1,
    M_ABS_X      = 5'd2,
    M_ABS_Y      = 5'd3,
    M_LONG       = 5'd4,
    M_LONG_X     = 5'd5,
    M_DP         = 5'd6,
    M_DP_X       = 5'd7,
    M_DP_Y       = 5'd8,
    M_SREL       = 5'd9,
    M_DP_IND     = 5'd10,
    M_DP_XIND    = 5'd11,
    M_DP_IND_Y   = 5'd12,
    M_DP_LIND    = 5'd13,
    M_DP_LIND_Y  = 5'd14,
    M_SREL_IND_Y = 5'd15,
    M_JMP_IND    = 5'd16,
    M_JMP_XIND   = 5'd17
  } ea_mode_e;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [LONG_W-1:0] opnd;
    logic [WORD_W-1:0] x;
    logic [WORD_W-1:0] y;
    logic [WORD_W-1:0] d;
    logic [WORD_W-1:0] s;
    logic [BANK_W-1:0] db;
    logic [BANK_W-1:0] pb;
  } ea_ctx_t;
endpackage

// File: rtl/ea_idx_mask.sv
module ea_idx_mask #(
  parameter int WIDTH  = 16,
  parameter int NARROW = 8
) (
  input  logic [WIDTH-1:0] idx_raw,
  input  logic             narrow,
  output logic [WIDTH-1:0] idx_eff
);
  generate
    if (WIDTH > NARROW) begin : g_mask
      assign idx_eff = narrow ? {{(WIDTH-NARROW){1'b0}}, idx_raw[NARROW-1:0]} : idx_raw;
    end else begin : g_pass
      assign idx_eff = idx_raw;
    end
  endgenerate
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
(
  input  ea_ctx_t           ctx,
  input  logic [LONG_W-1:0] ptr_data,
  output logic              need_ptr,
  output logic              ptr_long,
  output logic [LONG_W-1:0] ptr_addr,
  output logic [LONG_W-1:0] direct_ea,
  output logic [LONG_W-1:0] ind_ea
);
  localparam logic [BANK_W-1:0] BANK0 = '0;
  localparam int EXT_W = WORD_W - BYTE_W;

  logic [WORD_W-1:0] op16, op8w, dp_sum, dp_x, dp_y, sr_sum, abs_x16;
  logic [LONG_W-1:0] db_op, pb_op, long_op, x24, y24, db_ptr, pb_ptr, ptr24;
  ea_mode_e m;

  always_comb begin
    m       = ea_mode_e'(ctx.mode);
    op16    = ctx.opnd[WORD_W-1:0];
    op8w    = {{EXT_W{1'b0}}, ctx.opnd[BYTE_W-1:0]};
    dp_sum  = ctx.d + op8w;
    dp_x    = dp_sum + ctx.x;
    dp_y    = dp_sum + ctx.y;
    sr_sum  = ctx.s + op8w;
    abs_x16 = op16 + ctx.x;
    x24     = {BANK0, ctx.x};
    y24     = {BANK0, ctx.y};
    db_op   = {ctx.db, op16};
    pb_op   = {ctx.pb, op16};
    long_op = ctx.opnd;
    db_ptr  = {ctx.db, ptr_data[WORD_W-1:0]};
    pb_ptr  = {ctx.pb, ptr_data[WORD_W-1:0]};
    ptr24   = ptr_data;
  end

  always_comb begin
    need_ptr  = 1'b0;
    ptr_long  = 1'b0;
    ptr_addr  = '0;
    direct_ea = '0;
    ind_ea    = '0;
    case (m)
      M_ABS_DATA:   direct_ea = db_op;
      M_ABS_CTRL:   direct_ea = pb_op;
      M_ABS_X:      direct_ea = db_op + x24;
      M_ABS_Y:      direct_ea = db_op + y24;
      M_LONG:       direct_ea = long_op;
      M_LONG_X:     direct_ea = long_op + x24;
      M_DP:         direct_ea = {BANK0, dp_sum};
      M_DP_X:       direct_ea = {BANK0, dp_x};
      M_DP_Y:       direct_ea = {BANK0, dp_y};
      M_SREL:       direct_ea = {BANK0, sr_sum};
      M_DP_IND: begin
        need_ptr = 1'b1; ptr_addr = {BANK0, dp_sum}; ind_ea = db_ptr;
      end
      M_DP_XIND: begin
        need_ptr = 1'b1; ptr_addr = {BANK0, dp_x}; ind_ea = db_ptr;
      end
      M_DP_IND_Y: begin
        need_ptr = 1'b1; ptr_addr = {BANK0, dp_sum}; ind_ea = db_ptr + y24;
      end
      M_DP_LIND: begin
        need_ptr = 1'b1; ptr_long = 1'b1; ptr_addr = {BANK0, dp_sum}; ind_ea = ptr24;
      end
      M_DP_LIND_Y: begin
        need_ptr = 1'b1; ptr_long = 1'b1; ptr_addr = {BANK0, dp_sum}; ind_ea = ptr24 + y24;
      end
      M_SREL_IND_Y: begin
        need_ptr = 1'b1; ptr_addr = {BANK0, sr_sum}; ind_ea = db_ptr + y24;
      end
      M_JMP_IND: begin
        need_ptr = 1'b1; ptr_addr = {BANK0, op16}; ind_ea = pb_ptr;
      end
      M_JMP_XIND: begin
        need_ptr = 1'b1; ptr_addr = {ctx.pb, abs_x16}; ind_ea = pb_ptr;
      end
      default:      direct_ea = db_op;
    endcase
  end
endmodule

// File: rtl/ea_ptr_port.sv
module ea_ptr_port #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch,
  input  logic [AW-1:0] launch_addr,
  input  logic          launch_long,
  input  logic          ack,
  output logic          req,
  output logic [AW-1:0] addr,
  output logic          is_long,
  output logic          done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req     <= 1'b0;
      addr    <= '0;
      is_long <= 1'b0;
    end else if (!req && launch) begin
      req     <= 1'b1;
      addr    <= launch_addr;
      is_long <= launch_long;
    end else if (req && ack) begin
      req     <= 1'b0;
    end
  end

  assign done = req && ack;

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req && !ack |=> req && $stable(addr) && $stable(is_long));

  // R8
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    req && ack |=> !req);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_pkg::*;
#(
  parameter int IDX_W  = WORD_W,
  parameter int NAR_W  = BYTE_W,
  parameter int EA_W   = LONG_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [MODE_W-1:0]    mode,
  input  logic [EA_W-1:0]      opnd,
  input  logic [IDX_W-1:0]     idx_x,
  input  logic [IDX_W-1:0]     idx_y,
  input  logic [IDX_W-1:0]     dpage,
  input  logic [IDX_W-1:0]     sptr,
  input  logic [EA_W-IDX_W-1:0] dbank,
  input  logic [EA_W-IDX_W-1:0] pbank,
  input  logic                 idx_narrow,
  output logic                 ptr_req,
  output logic [EA_W-1:0]      ptr_addr,
  output logic                 ptr_long,
  input  logic                 ptr_ack,
  input  logic [EA_W-1:0]      ptr_data,
  output logic [EA_W-1:0]      ea,
  output logic                 ea_valid,
  output logic                 busy
);
  localparam int NIDX = 2;

  logic [IDX_W-1:0] idx_raw [NIDX];
  logic [IDX_W-1:0] idx_eff [NIDX];

  assign idx_raw[0] = idx_x;
  assign idx_raw[1] = idx_y;

  generate
    for (genvar i = 0; i < NIDX; i++) begin : g_idx
      ea_idx_mask #(.WIDTH(IDX_W), .NARROW(NAR_W)) u_mask (
        .idx_raw (idx_raw[i]),
        .narrow  (idx_narrow),
        .idx_eff (idx_eff[i])
      );
    end
  endgenerate

  ea_ctx_t live_ctx, ctx_q, sel_ctx;

  always_comb begin
    live_ctx.mode = mode;
    live_ctx.opnd = opnd;
    live_ctx.x    = idx_eff[0];
    live_ctx.y    = idx_eff[1];
    live_ctx.d    = dpage;
    live_ctx.s    = sptr;
    live_ctx.db   = dbank;
    live_ctx.pb   = pbank;
  end

  assign sel_ctx = busy ? ctx_q : live_ctx;

  logic            need_ptr, calc_long, accept, done;
  logic [EA_W-1:0] calc_paddr, direct_ea, ind_ea;

  ea_addr_calc u_calc (
    .ctx       (sel_ctx),
    .ptr_data  (ptr_data),
    .need_ptr  (need_ptr),
    .ptr_long  (calc_long),
    .ptr_addr  (calc_paddr),
    .direct_ea (direct_ea),
    .ind_ea    (ind_ea)
  );

  assign accept = start && !busy;

  ea_ptr_port #(.AW(EA_W)) u_port (
    .clk         (clk),
    .rst         (rst),
    .launch      (accept && need_ptr),
    .launch_addr (calc_paddr),
    .launch_long (calc_long),
    .ack         (ptr_ack),
    .req         (ptr_req),
    .addr        (ptr_addr),
    .is_long     (ptr_long),
    .done        (done)
  );

  assign busy = ptr_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q    <= '0;
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      ea_valid <= 1'b0;
      if (accept) begin
        ctx_q <= live_ctx;
        if (!need_ptr) begin
          ea       <= direct_ea;
          ea_valid <= 1'b1;
        end
      end else if (done) begin
        ea       <= ind_ea;
        ea_valid <= 1'b1;
      end
    end
  end

  // R2
  direct_lat_chk: assert property (@(posedge clk) disable iff (rst)
    accept && !need_ptr |=> ea_valid && !ptr_req);

  // R7
  ind_launch_chk: assert property (@(posedge clk) disable iff (rst)
    accept && need_ptr |=> ptr_req && !ea_valid);

  // R8
  ack_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_req && ptr_ack |=> ea_valid);

  // R11
  busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_req |-> !ea_valid);
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  mode = '0;
  logic [23:0] opnd = '0;
  logic [15:0] idx_x = 16'h0134, idx_y = 16'h00F5, dpage = 16'h1200, sptr = 16'h01F0;
  logic [7:0]  dbank = 8'h7E, pbank = 8'h02;
  logic        idx_narrow = 1'b0;
  logic        ptr_ack = 1'b0;
  logic [23:0] ptr_data = '0;
  logic        ptr_req, ptr_long, ea_valid, busy;
  logic [23:0] ptr_addr, ea;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ea_gen u_ea_gen (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .opnd(opnd),
    .idx_x(idx_x), .idx_y(idx_y), .dpage(dpage), .sptr(sptr),
    .dbank(dbank), .pbank(pbank), .idx_narrow(idx_narrow),
    .ptr_req(ptr_req), .ptr_addr(ptr_addr), .ptr_long(ptr_long),
    .ptr_ack(ptr_ack), .ptr_data(ptr_data),
    .ea(ea), .ea_valid(ea_valid), .busy(busy)
  );

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic t_direct(input string tag, input logic [4:0] m,
                          input logic [23:0] op, input logic [23:0] exp);
    @(negedge clk);
    mode = m; opnd = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " valid"}, {23'd0, ea_valid}, 24'd1);
    chk({tag, " ea"}, ea, exp);
  endtask

  task automatic t_ind(input string tag, input logic [4:0] m, input logic [23:0] op,
                       input logic [23:0] exp_pa, input logic exp_long, input int waits,
                       input logic [23:0] data, input logic [23:0] exp_ea);
    @(negedge clk);
    mode = m; opnd = op; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " req"}, {23'd0, ptr_req}, 24'd1);
    chk({tag, " paddr"}, ptr_addr, exp_pa);
    chk({tag, " long"}, {23'd0, ptr_long}, {23'd0, exp_long});
    for (int i = 0; i < waits; i++) begin
      mode = 5'd0; opnd = 24'hFFFFFF;
      @(negedge clk);
      chk({tag, " hold"}, {ptr_req, ea_valid, ptr_addr[21:0]}, {2'b10, exp_pa[21:0]});
    end
    ptr_ack = 1'b1; ptr_data = data;
    @(negedge clk);
    ptr_ack = 1'b0; ptr_data = 24'h5A5A5A;
    chk({tag, " valid"}, {22'd0, ea_valid, ptr_req}, 24'd2);
    chk({tag, " ea"}, ea, exp_ea);
  endtask

  task automatic t_busy_ignore();
    @(negedge clk);
    mode = 5'd10; opnd = 24'h000010; start = 1'b1;
    @(negedge clk);
    mode = 5'd0; opnd = 24'h003333;
    @(negedge clk);
    start = 1'b0;
    chk("R11 no valid while busy", {22'd0, ea_valid, ptr_req}, 24'd1);
    chk("R11 paddr kept", ptr_addr, 24'h001210);
    ptr_ack = 1'b1; ptr_data = 24'h000777;
    @(negedge clk);
    ptr_ack = 1'b0;
    chk("R11 result", ea, 24'h7E0777);
    @(negedge clk);
    chk("R11 single strobe", {23'd0, ea_valid}, 24'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {ea_valid, ptr_req, busy, ea[20:0]}, 24'd0);
    rst = 1'b0;
    // R2
    t_direct("R2 abs data", 5'd0, 24'h001234, 24'h7E1234);
    t_direct("R2 abs ctrl", 5'd1, 24'h001234, 24'h021234);
    // R3
    t_direct("R3 abs x carry", 5'd2, 24'h00FFF0, 24'h7F0124);
    t_direct("R3 abs y", 5'd3, 24'h001000, 24'h7E10F5);
    // R4
    t_direct("R4 long", 5'd4, 24'h123456, 24'h123456);
    t_direct("R4 long x", 5'd5, 24'h123456, 24'h12358A);
    idx_x = 16'h0002;
    t_direct("R4 long x wrap", 5'd5, 24'hFFFFFF, 24'h000001);
    idx_x = 16'h0134;
    // R5
    t_direct("R5 dp", 5'd6, 24'h000040, 24'h001240);
    t_direct("R5 dp x", 5'd7, 24'h000040, 24'h001374);
    t_direct("R5 dp y", 5'd8, 24'h000040, 24'h001335);
    t_direct("R5 srel", 5'd9, 24'h000005, 24'h0001F5);
    dpage = 16'hFFF0; sptr = 16'hFFFE;
    t_direct("R5 dp x wrap", 5'd7, 24'h000020, 24'h000144);
    t_direct("R5 srel wrap", 5'd9, 24'h000004, 24'h000002);
    dpage = 16'h1200; sptr = 16'h01F0;
    // R6
    idx_narrow = 1'b1;
    t_direct("R6 narrow x", 5'd2, 24'h00FFF0, 24'h7F0024);
    idx_y = 16'h12F5;
    t_ind("R6 narrow y ind", 5'd12, 24'h000010, 24'h001210, 1'b0, 0, 24'h00FFF0, 24'h7F00E5);
    idx_narrow = 1'b0; idx_y = 16'h00F5;
    // R7 R8 R9
    t_ind("R9 dp ind", 5'd10, 24'h000010, 24'h001210, 1'b0, 3, 24'hAB5678, 24'h7E5678);
    t_ind("R7 dp xind", 5'd11, 24'h000010, 24'h001344, 1'b0, 1, 24'h009ABC, 24'h7E9ABC);
    t_ind("R9 dp ind y", 5'd12, 24'h000010, 24'h001210, 1'b0, 2, 24'h00FFF0, 24'h7F00E5);
    t_ind("R7 dp lind", 5'd13, 24'h000020, 24'h001220, 1'b1, 0, 24'h345678, 24'h345678);
    t_ind("R9 dp lind y", 5'd14, 24'h000020, 24'h001220, 1'b1, 1, 24'h34FFF0, 24'h3500E5);
    t_ind("R8 srel ind y", 5'd15, 24'h000003, 24'h0001F3, 1'b0, 4, 24'h002000, 24'h7E20F5);
    // R10
    t_ind("R10 jmp ind", 5'd16, 24'h008000, 24'h008000, 1'b0, 1, 24'hEE4321, 24'h024321);
    t_ind("R10 jmp xind", 5'd17, 24'h00FFF0, 24'h020124, 1'b0, 0, 24'h001111, 24'h021111);
    // R11
    t_busy_ignore();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule